// File: doc/BRIEF.md
# Dual-Width Arithmetic Unit with Flag Nibble

This block is the arithmetic core of a small microcoded processor. Each cycle it combines two 16-bit operands with add, subtract, AND, or one of eight operations named by a 3-bit field from the instruction word. A size bit decides whether the operation runs on the low byte only or on the full 16 bits. The condition flags are computed at that same width, so an 8-bit compare gives correct 8-bit flags even when the result is thrown away.

Alongside the main result the block offers a second output that holds the result moved one place toward bit 0, which gives a one-bit logical right shift. A left shift needs no extra path: the sequencer adds the operand to itself and keeps the flag strobe low. The carry into the adder comes either from a constant or from the stored carry flag, which allows multi-word arithmetic. The same-cycle flags go straight out. A flag register loads them only when the sequencer raises a strobe. Four branch conditions are derived from the stored flags.

Top module: `flag_alu`

## Requirements
- R1: While `rstN` is low, the held flag nibble is cleared to 4'b0000.
- R2: `opSel` picks the operation: 0 uses `irOp`, 1 is AND, 2 is SUB, 3 is ADD. The `irOp` codes are 0 ADD, 1 SUB, 2 AND, 3 OR, 4 XOR, 5 pass B, 6 A AND NOT B, 7 pass A.
- R3: With `wide`=1 all 16 bits take part. With `wide`=0 only bits 7:0 of both operands are used, and `result[15:8]` is zero.
- R4: The flag nibble is {V,S,C,Z} in bits 3..0. Z is set when the result is zero at the selected width. S is the top bit of the selected width. C is the carry out of that bit. V is set for signed overflow at that width. These are presented on `rawFlags` in the same cycle.
- R5: SUB computes A + ~B + cin. With `carrySel`=0 the carry-in is 1, and C=1 means no borrow occurred.
- R6: With `carrySel`=1, ADD and SUB take their carry-in from the held C flag, as it stood before the current clock edge.
- R7: Logic and pass operations report C=0 and V=0.
- R8: On a rising edge with `latchFlags`=1, `heldFlags` loads `rawFlags`. With `latchFlags`=0 it keeps its value. This is how a left shift (A+A) leaves the flags alone.
- R9: `shiftOut` is the result shifted one bit lower with a zero fill at the top of the selected width. In 16-bit mode it is {0,result[15:1]}. In 8-bit mode it is {9'b0,result[7:1]}.
- R10: The branch conditions come from the held flags: `ltU`=~C, `leU`=~C|Z, `ltS`=S^V, `leS`=(S^V)|Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| opSel | input | 2 | Operation source select |
| irOp | input | 3 | Operation code from the instruction word |
| wide | input | 1 | 1 = 16-bit, 0 = 8-bit operation |
| carrySel | input | 1 | 1 = carry-in from held C |
| latchFlags | input | 1 | Load the flag register at the next edge |
| result | output | 16 | Operation result |
| shiftOut | output | 16 | Result shifted right by one |
| rawFlags | output | 4 | Same-cycle flags {V,S,C,Z} |
| heldFlags | output | 4 | Stored flags {V,S,C,Z} |
| ltU | output | 1 | Unsigned less-than from held flags |
| leU | output | 1 | Unsigned less-or-equal from held flags |
| ltS | output | 1 | Signed less-than from held flags |
| leS | output | 1 | Signed less-or-equal from held flags |

## Verification
Two functions can meet in one cycle: the adder reads the held carry as its carry-in, and the flag register overwrites that same carry at the same edge. The bench provokes this with back-to-back multi-word additions that have both `carrySel` and `latchFlags` high. The raw result must use the carry from before the edge, and the held flags must then show the new carry. A second overlap is a left shift (A+A with the strobe low) placed right after a flag-setting compare. There the branch outputs must still reflect the compare.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DATA_W   = 16;
  localparam int NARROW_W = 8;

  typedef enum logic [2:0] {
    FN_ADD  = 3'd0,
    FN_SUB  = 3'd1,
    FN_AND  = 3'd2,
    FN_OR   = 3'd3,
    FN_XOR  = 3'd4,
    FN_PASB = 3'd5,
    FN_ANDN = 3'd6,
    FN_PASA = 3'd7
  } aluFn_e;

  typedef struct packed {
    logic v;
    logic s;
    logic c;
    logic z;
  } flags_t;

  typedef struct packed {
    aluFn_e fn;
    logic   arith;
    logic   invB;
    logic   useHeldC;
    logic   wide;
    logic   latch;
  } strobe_t;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [1:0] opSel,
  input  logic [2:0] irOp,
  input  logic       wide,
  input  logic       carrySel,
  input  logic       latchFlags,
  output strobe_t    strobe
);
  aluFn_e fn;

  always_comb begin
    unique case (opSel)
      2'd0:    fn = aluFn_e'(irOp);
      2'd1:    fn = FN_AND;
      2'd2:    fn = FN_SUB;
      default: fn = FN_ADD;
    endcase
  end

  always_comb begin
    strobe.fn       = fn;
    strobe.arith    = (fn == FN_ADD) || (fn == FN_SUB);
    strobe.invB     = (fn == FN_SUB);
    strobe.useHeldC = carrySel && ((fn == FN_ADD) || (fn == FN_SUB));
    strobe.wide     = wide;
    strobe.latch    = latchFlags;
  end
endmodule

// File: rtl/alu_path.sv
module alu_path
  import alu_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NW = NARROW_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strobe,
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opB,
  output logic [DW-1:0] result,
  output logic [DW-1:0] shiftOut,
  output flags_t        rawFlags,
  output flags_t        heldFlags,
  output logic          ltU,
  output logic          leU,
  output logic          ltS,
  output logic          leS
);
  localparam int HW = DW - NW;

  logic [DW-1:0] bIn;
  logic          cin;
  logic [DW:0]   sumW;
  logic [NW:0]   sumN;
  logic [DW-1:0] logicOut;
  logic [DW-1:0] fullRes;
  flags_t        wideFlags;
  flags_t        narrowFlags;

  assign bIn = strobe.invB ? ~opB : opB;
  assign cin = strobe.useHeldC ? heldFlags.c : strobe.invB;

  assign sumW = {1'b0, opA} + {1'b0, bIn} + {{DW{1'b0}}, cin};
  assign sumN = {1'b0, opA[NW-1:0]} + {1'b0, bIn[NW-1:0]} + {{NW{1'b0}}, cin};

  always_comb begin
    unique case (strobe.fn)
      FN_AND:  logicOut = opA & opB;
      FN_OR:   logicOut = opA | opB;
      FN_XOR:  logicOut = opA ^ opB;
      FN_PASB: logicOut = opB;
      FN_ANDN: logicOut = opA & ~opB;
      default: logicOut = opA;
    endcase
  end

  assign fullRes = strobe.arith ? sumW[DW-1:0] : logicOut;

  always_comb begin
    wideFlags.z = (fullRes == '0);
    wideFlags.s = fullRes[DW-1];
    wideFlags.c = strobe.arith && sumW[DW];
    wideFlags.v = strobe.arith && (opA[DW-1] == bIn[DW-1]) && (sumW[DW-1] != opA[DW-1]);
  end

  always_comb begin
    narrowFlags.z = (fullRes[NW-1:0] == '0);
    narrowFlags.s = fullRes[NW-1];
    narrowFlags.c = strobe.arith && sumN[NW];
    narrowFlags.v = strobe.arith && (opA[NW-1] == bIn[NW-1]) && (sumN[NW-1] != opA[NW-1]);
  end

  always_comb begin
    if (strobe.wide) begin
      result   = fullRes;
      shiftOut = {1'b0, fullRes[DW-1:1]};
      rawFlags = wideFlags;
    end else begin
      result   = {{HW{1'b0}}, fullRes[NW-1:0]};
      shiftOut = {{(HW+1){1'b0}}, fullRes[NW-1:1]};
      rawFlags = narrowFlags;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             heldFlags <= '0;
    else if (strobe.latch) heldFlags <= rawFlags;
  end

  assign ltU = ~heldFlags.c;
  assign leU = ~heldFlags.c | heldFlags.z;
  assign ltS = heldFlags.s ^ heldFlags.v;
  assign leS = (heldFlags.s ^ heldFlags.v) | heldFlags.z;
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] opA,
  input  logic [15:0] opB,
  input  logic [1:0]  opSel,
  input  logic [2:0]  irOp,
  input  logic        wide,
  input  logic        carrySel,
  input  logic        latchFlags,
  output logic [15:0] result,
  output logic [15:0] shiftOut,
  output logic [3:0]  rawFlags,
  output logic [3:0]  heldFlags,
  output logic        ltU,
  output logic        leU,
  output logic        ltS,
  output logic        leS
);
  strobe_t strobe;
  flags_t  rawF;
  flags_t  heldF;

  alu_ctrl u_ctrl (
    .opSel      (opSel),
    .irOp       (irOp),
    .wide       (wide),
    .carrySel   (carrySel),
    .latchFlags (latchFlags),
    .strobe     (strobe)
  );

  alu_path #(.DW(16), .NW(8)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .opA       (opA),
    .opB       (opB),
    .result    (result),
    .shiftOut  (shiftOut),
    .rawFlags  (rawF),
    .heldFlags (heldF),
    .ltU       (ltU),
    .leU       (leU),
    .ltS       (ltS),
    .leS       (leS)
  );

  assign rawFlags  = rawF;
  assign heldFlags = heldF;
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] opA,
  input logic [15:0] opB,
  input logic [1:0]  opSel,
  input logic [2:0]  irOp,
  input logic        wide,
  input logic        carrySel,
  input logic        latchFlags,
  input logic [15:0] result,
  input logic [15:0] shiftOut,
  input logic [3:0]  rawFlags,
  input logic [3:0]  heldFlags,
  input logic        ltU,
  input logic        leU,
  input logic        ltS,
  input logic        leS
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !latchFlags |=> $stable(heldFlags));

  p_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    latchFlags |=> heldFlags == $past(rawFlags));

  p_narrow_hi_r3: assert property (@(posedge clk) disable iff (!rstN)
    !wide |-> result[15:8] == 8'h00);

  p_logic_cv_r7: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 2'd1) |-> (rawFlags[1] == 1'b0 && rawFlags[3] == 1'b0));

  p_shift_wide_r9: assert property (@(posedge clk) disable iff (!rstN)
    wide |-> shiftOut == {1'b0, result[15:1]});

  p_lt_le_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ltU |-> leU) and (ltS |-> leS));
endmodule

bind flag_alu flag_alu_chk u_chk (.*);

// File: tb/flag_alu_bench.sv
module flag_alu_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic [1:0]  opSel = 2'd3;
  logic [2:0]  irOp = '0;
  logic        wide = 1'b1, carrySel = 1'b0, latchFlags = 1'b0;
  logic [15:0] result, shiftOut;
  logic [3:0]  rawFlags, heldFlags;
  logic        ltU, leU, ltS, leS;

  int nChk = 0;
  int nFail = 0;
  logic [3:0] expHeld = 4'b0;

  always #5 clk = ~clk;

  flag_alu u_flag_alu (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model from the requirements: returns {flags, result}
  function automatic logic [19:0] model(logic [15:0] a, logic [15:0] b, logic [1:0] sel,
                                        logic [2:0] ir, logic w, logic cs, logic hc);
    logic [2:0] fn;
    logic [15:0] bb, r;
    logic [16:0] s17;
    logic [8:0] s9;
    logic ci, c, v, z, sg;
    fn = (sel == 2'd0) ? ir : (sel == 2'd1) ? 3'd2 : (sel == 2'd2) ? 3'd1 : 3'd0;
    c = 1'b0; v = 1'b0;
    if (fn <= 3'd1) begin
      bb = (fn == 3'd1) ? ~b : b;
      ci = cs ? hc : (fn == 3'd1);
      if (w) begin
        s17 = {1'b0, a} + {1'b0, bb} + {16'd0, ci};
        r = s17[15:0]; c = s17[16];
        v = (a[15] == bb[15]) && (r[15] != a[15]);
      end else begin
        s9 = {1'b0, a[7:0]} + {1'b0, bb[7:0]} + {8'd0, ci};
        r = {8'h00, s9[7:0]}; c = s9[8];
        v = (a[7] == bb[7]) && (r[7] != a[7]);
      end
    end else begin
      case (fn)
        3'd2: r = a & b;
        3'd3: r = a | b;
        3'd4: r = a ^ b;
        3'd5: r = b;
        3'd6: r = a & ~b;
        default: r = a;
      endcase
      if (!w) r[15:8] = 8'h00;
    end
    z = (r == 16'h0);
    sg = w ? r[15] : r[7];
    return {v, sg, c, z, r};
  endfunction

  task automatic runOp(string tag, logic [15:0] a, logic [15:0] b, logic [1:0] sel,
                       logic [2:0] ir, logic w, logic cs, logic lf);
    logic [19:0] e;
    logic [15:0] eShift;
    @(negedge clk);
    opA = a; opB = b; opSel = sel; irOp = ir; wide = w; carrySel = cs; latchFlags = lf;
    #1;
    e = model(a, b, sel, ir, w, cs, expHeld[1]);
    eShift = w ? {1'b0, e[15:1]} : {9'd0, e[7:1]};
    chk({tag, " result"}, result, e[15:0]);
    chk({tag, " raw flags"}, {12'd0, rawFlags}, {12'd0, e[19:16]});
    chk({tag, " R9 shiftOut"}, shiftOut, eShift);
    @(posedge clk);
    #1;
    if (lf) expHeld = e[19:16];
    chk({tag, " R8 heldFlags"}, {12'd0, heldFlags}, {12'd0, expHeld});
    chk({tag, " R10 branch conds"}, {12'd0, ltU, leU, ltS, leS},
        {12'd0, ~expHeld[1], ~expHeld[1] | expHeld[0],
         expHeld[2] ^ expHeld[3], (expHeld[2] ^ expHeld[3]) | expHeld[0]});
    latchFlags = 1'b0;
  endtask

  task automatic testReset();
    #1;
    chk("R1 heldFlags in reset", {12'd0, heldFlags}, 16'd0);
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R1 heldFlags after reset", {12'd0, heldFlags}, 16'd0);
  endtask

  task automatic testArith16();
    runOp("R2 R4 add16", 16'h1234, 16'h4321, 2'd3, 3'd0, 1'b1, 1'b0, 1'b1);
    runOp("R4 add16 overflow", 16'h7FFF, 16'h0001, 2'd3, 3'd0, 1'b1, 1'b0, 1'b1);
    runOp("R5 sub16 equal", 16'hBEEF, 16'hBEEF, 2'd2, 3'd0, 1'b1, 1'b0, 1'b1);
    runOp("R5 sub16 borrow", 16'h0003, 16'h0010, 2'd2, 3'd0, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic testNarrow();
    runOp("R3 add8 wrap", 16'hABFF, 16'h1201, 2'd3, 3'd0, 1'b0, 1'b0, 1'b1);
    // 5 - (-128): signed overflow, borrow, ltS must be 0
    runOp("R3 R4 cmp8 overflow", 16'h7705, 16'h0080, 2'd2, 3'd0, 1'b0, 1'b0, 1'b1);
    runOp("R3 R10 cmp8 less", 16'hFF80, 16'h0005, 2'd2, 3'd0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testLogic();
    runOp("R7 and", 16'hF0F3, 16'h3C3F, 2'd1, 3'd0, 1'b1, 1'b0, 1'b1);
    for (int i = 2; i < 8; i++)
      runOp("R2 R7 ir logic", 16'hA5C3, 16'h0FF0, 2'd0, 3'(i), 1'b1, 1'b1, 1'b1);
    runOp("R2 ir add", 16'h00FF, 16'h0001, 2'd0, 3'd0, 1'b0, 1'b0, 1'b1);
    runOp("R2 ir sub", 16'h0010, 16'h0001, 2'd0, 3'd1, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic testCarryChain();
    // low words: carry out, latched; then high words use held C while it is overwritten
    runOp("R6 chain lo", 16'hFFFF, 16'h0001, 2'd3, 3'd0, 1'b1, 1'b0, 1'b1);
    runOp("R6 chain hi", 16'h0001, 16'hFFFF, 2'd3, 3'd0, 1'b1, 1'b1, 1'b1);
    runOp("R6 chain top", 16'h1000, 16'h0000, 2'd3, 3'd0, 1'b1, 1'b1, 1'b1);
    runOp("R6 sbc held0", 16'h0008, 16'h0003, 2'd2, 3'd0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic testShifts();
    runOp("R10 compare", 16'h0002, 16'h0009, 2'd2, 3'd0, 1'b1, 1'b0, 1'b1);
    runOp("R8 shl no latch", 16'h8421, 16'h8421, 2'd3, 3'd0, 1'b1, 1'b0, 1'b0);
    runOp("R8 shl8 no latch", 16'h00C1, 16'h00C1, 2'd3, 3'd0, 1'b0, 1'b0, 1'b0);
    runOp("R9 shr16", 16'h8001, 16'h0000, 2'd0, 3'd7, 1'b1, 1'b0, 1'b0);
    runOp("R9 shr8", 16'hFF81, 16'h0000, 2'd0, 3'd7, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    testReset();
    testArith16();
    testNarrow();
    testLogic();
    testCarryChain();
    testShifts();
    summary();
    $finish;
  end
endmodule